// File: doc/BRIEF.md
# Four-Mode Timer with Compare-Driven Waveform Output

This block is an 8-bit timer/counter with one compare channel. It advances on clock cycles where an external prescaler asserts the count-enable input. It has four modes: a free-running wrap counter, a counter that restarts at the compare value, a single-slope PWM and a dual-slope (up/down) PWM. One waveform pin is driven by compare events. Two sticky flags record overflow/bottom events and compare events, and software can clear each one with a strobe.

The exact cycle in which each output changes is part of the contract. In the single-slope modes, every flag and pin change happens on the enabled tick that takes the counter off the matching value. In dual-slope mode, the pin and the compare flag change on the tick that brings the counter onto the compare value. In both PWM modes, a compare write goes to a shadow register first. The shadow is copied to the active register only at the end of a period, so an update can never cut a pulse short.

Top module: `pwm_timer`

## Requirements
- R1: While rst_ni is low, and until the first enabled tick after it rises, cnt_o, pwm_o, ovf_flag_o and cmp_flag_o are all 0, and the counter direction is up.
- R2: The counter, pin and flags change only on clock edges where cnt_en_i is 1. With cnt_en_i at 0, cnt_o holds its value.
- R3: mode_i encodes 0 = wrap, 1 = restart-on-compare, 2 = single-slope PWM, 3 = dual-slope PWM. In modes 0 and 2 the counter runs 0..255 and then wraps, giving a period of 256 ticks. In mode 1 it returns to 0 on the tick after it equals the active compare value N, giving a period of N+1 ticks.
- R4: In modes 0, 1 and 2, ovf_flag_o is set by the enabled tick that takes the counter from 255 to 0. In mode 1 with a compare value below 255 the flag therefore never sets.
- R5: In modes 0, 1 and 2, cmp_flag_o is set by the enabled tick that leaves a count equal to the active compare value, one tick after equality.
- R6: In modes 0 and 1, pwm_o toggles on each compare event of R5.
- R7: In mode 2, pwm_o goes to 1 on the tick that wraps 255 to 0. It goes to 0 on the tick after the count equals the compare value. If both happen on the same tick, going to 1 wins. With a compare value of C, the pin is high for counts 0..C.
- R8: In mode 3, the counter steps 0,1,...,255,254,...,1,0,1,..., giving a period of 510 ticks. ovf_flag_o is set on the tick on which a downward step reaches 0.
- R9: In mode 3, pwm_o and cmp_flag_o change on the same tick on which the counter reaches the compare value. The pin goes to 0 when that step is upward and to 1 when it is downward. A compare value of 0 always drives 0, and a compare value of 255 always drives 1.
- R10: A compare write takes effect at once in modes 0 and 1. In mode 2 the written value becomes active on the tick that wraps 255 to 0. In mode 3 it becomes active on the tick that reaches bottom. Until then, the previous value governs.
- R11: Each flag stays set until its clear strobe is sampled high. If a set event and a clear strobe fall on the same tick, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable from the prescaler |
| mode_i | input | 2 | Operating mode (encoding in R3) |
| ocr_we_i | input | 1 | Compare value write strobe |
| ocr_wdata_i | input | 8 | Compare value to write |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| cmp_clr_i | input | 1 | Clears the compare flag |
| cnt_o | output | 8 | Current count |
| pwm_o | output | 1 | Waveform / compare output pin |
| ovf_flag_o | output | 1 | Sticky overflow/bottom flag |
| cmp_flag_o | output | 1 | Sticky compare-match flag |

## Verification
The properties assume that mode_i stays constant between resets. A mode change while counting could, for example, leave the dual-slope counter at 255 with the direction still up. The restart-on-compare property also assumes that no compare write lands on the tick it observes.

The bench therefore sets the mode while reset is held. It issues every compare write with cnt_en_i low, so a write never coincides with a counting tick or a shadow reload.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
package pwm_timer_pkg;
  typedef enum logic [1:0] {
    MODE_WRAP  = 2'd0,
    MODE_CTC   = 2'd1,
    MODE_FAST  = 2'd2,
    MODE_PHASE = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter
  import pwm_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  tmr_mode_e    mode_i,
  input  logic         tick_i,
  input  logic [W-1:0] ocr_i,
  output logic [W-1:0] cnt_o,
  output logic         up_o,
  output logic         at_max_tick_o,
  output logic         ovf_evt_o,
  output logic         cmp_evt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;
  logic         dir_q, dir_d;
  logic         single;

  assign single = (mode_i != MODE_PHASE);

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (tick_i) begin
      if (single) begin
        dir_d = 1'b1;
        if (mode_i == MODE_CTC && cnt_q == ocr_i) cnt_d = '0;
        else                                      cnt_d = cnt_q + ONE;
      end else if (dir_q) begin
        cnt_d = cnt_q + ONE;
        if (cnt_d == MAX) dir_d = 1'b0;
      end else begin
        cnt_d = cnt_q - ONE;
        if (cnt_d == '0) dir_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  // single slope acts one tick after equality; dual slope on arrival
  assign at_max_tick_o = tick_i && single && (cnt_q == MAX);
  assign ovf_evt_o = tick_i && (single ? (cnt_q == MAX) : (!dir_q && cnt_d == '0));
  assign cmp_evt_o = tick_i && (single ? (cnt_q == ocr_i) : (cnt_d == ocr_i));
  assign cnt_o     = cnt_q;
  assign up_o      = dir_q;
endmodule

// File: rtl/tmr_cmp_buf.sv
`timescale 1ns/1ps
module tmr_cmp_buf
  import pwm_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  tmr_mode_e    mode_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         reload_i,
  output logic [W-1:0] ocr_o
);
  logic [W-1:0] shadow_q, act_q;
  logic         buffered;

  assign buffered = (mode_i == MODE_FAST) || (mode_i == MODE_PHASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      if (we_i) shadow_q <= wdata_i;
      if (we_i && !buffered)         act_q <= wdata_i;
      else if (buffered && reload_i) act_q <= shadow_q;
    end
  end

  assign ocr_o = act_q;
endmodule

// File: rtl/tmr_wave.sv
`timescale 1ns/1ps
module tmr_wave
  import pwm_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  tmr_mode_e    mode_i,
  input  logic         at_max_tick_i,
  input  logic         cmp_evt_i,
  input  logic         up_i,
  input  logic [W-1:0] ocr_i,
  output logic         pwm_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic pin_q, pin_d;

  always_comb begin
    pin_d = pin_q;
    unique case (mode_i)
      MODE_WRAP, MODE_CTC: if (cmp_evt_i) pin_d = ~pin_q;
      MODE_FAST: begin
        if (at_max_tick_i)  pin_d = 1'b1;
        else if (cmp_evt_i) pin_d = 1'b0;
      end
      MODE_PHASE: begin
        if (cmp_evt_i) begin
          if (ocr_i == MAX)     pin_d = 1'b1;
          else if (ocr_i == '0) pin_d = 1'b0;
          else                  pin_d = ~up_i;
        end
      end
      default: pin_d = pin_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_d;
  end

  assign pwm_o = pin_q;
endmodule

// File: rtl/tmr_flag.sv
`timescale 1ns/1ps
module tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/pwm_timer.sv
`timescale 1ns/1ps
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_en_i,
  input  logic [1:0]   mode_i,
  input  logic         ocr_we_i,
  input  logic [W-1:0] ocr_wdata_i,
  input  logic         ovf_clr_i,
  input  logic         cmp_clr_i,
  output logic [W-1:0] cnt_o,
  output logic         pwm_o,
  output logic         ovf_flag_o,
  output logic         cmp_flag_o
);
  localparam int NFLAG = 2;

  tmr_mode_e    mode;
  logic [W-1:0] ocr_act;
  logic         up, at_max_tick, ovf_evt, cmp_evt, reload;
  logic [NFLAG-1:0] flag_set, flag_clr, flag_q;

  assign mode = tmr_mode_e'(mode_i);
  // shadow copy: leaving TOP in fast PWM, arriving at BOTTOM in dual slope
  assign reload = (mode == MODE_FAST) ? at_max_tick :
                  (mode == MODE_PHASE) ? ovf_evt : 1'b0;

  tmr_counter #(.W(W)) u_cnt (
    .clk_i, .rst_ni, .mode_i(mode), .tick_i(cnt_en_i), .ocr_i(ocr_act),
    .cnt_o, .up_o(up), .at_max_tick_o(at_max_tick),
    .ovf_evt_o(ovf_evt), .cmp_evt_o(cmp_evt)
  );

  tmr_cmp_buf #(.W(W)) u_buf (
    .clk_i, .rst_ni, .mode_i(mode), .we_i(ocr_we_i), .wdata_i(ocr_wdata_i),
    .reload_i(reload), .ocr_o(ocr_act)
  );

  tmr_wave #(.W(W)) u_wave (
    .clk_i, .rst_ni, .mode_i(mode), .at_max_tick_i(at_max_tick),
    .cmp_evt_i(cmp_evt), .up_i(up), .ocr_i(ocr_act), .pwm_o
  );

  assign flag_set = {cmp_evt, ovf_evt};
  assign flag_clr = {cmp_clr_i, ovf_clr_i};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    tmr_flag u_flag (
      .clk_i, .rst_ni, .set_i(flag_set[g]), .clr_i(flag_clr[g]), .flag_o(flag_q[g])
    );
  end

  assign ovf_flag_o = flag_q[0];
  assign cmp_flag_o = flag_q[1];
endmodule

// File: rtl/pwm_timer_chk.sv
`timescale 1ns/1ps
module pwm_timer_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cnt_en_i,
  input logic [1:0]   mode_i,
  input logic [W-1:0] cnt_o,
  input logic [W-1:0] ocr_act,
  input logic         pwm_o,
  input logic         ovf_flag_o,
  input logic         cmp_flag_o,
  input logic         ovf_clr_i,
  input logic         ovf_evt,
  input logic         cmp_evt
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> $stable(cnt_o)); // R2

  AST_WRAP_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && cnt_en_i && cnt_o == MAX) |=> (ovf_flag_o && cnt_o == '0)); // R4

  AST_CTC_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && cnt_en_i && cnt_o == ocr_act) |=> (cnt_o == '0 && cmp_flag_o)); // R5

  AST_FAST_BOTTOM_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && cnt_en_i && cnt_o == MAX) |=> pwm_o); // R7

  AST_PHASE_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3 && cnt_en_i && cnt_o == MAX) |=> (cnt_o == MAX - 1'b1)); // R8

  AST_FLAG_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt |=> ovf_flag_o); // R11

  AST_FLAG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && !ovf_evt) |=> !ovf_flag_o); // R11

  AST_CMP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_evt |=> cmp_flag_o); // R5
endmodule

bind pwm_timer pwm_timer_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt_en_i(cnt_en_i), .mode_i(mode_i),
  .cnt_o(cnt_o), .ocr_act(ocr_act), .pwm_o(pwm_o), .ovf_flag_o(ovf_flag_o),
  .cmp_flag_o(cmp_flag_o), .ovf_clr_i(ovf_clr_i), .ovf_evt(ovf_evt), .cmp_evt(cmp_evt)
);

// File: tb/pwm_timer_tb.sv
`timescale 1ns/1ps
module pwm_timer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cnt_en_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic       ocr_we_i = 1'b0;
  logic [7:0] ocr_wdata_i = 8'd0;
  logic       ovf_clr_i = 1'b0;
  logic       cmp_clr_i = 1'b0;
  logic [7:0] cnt_o;
  logic       pwm_o, ovf_flag_o, cmp_flag_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pwm_timer u_dut (
    .clk_i, .rst_ni, .cnt_en_i, .mode_i, .ocr_we_i, .ocr_wdata_i,
    .ovf_clr_i, .cmp_clr_i, .cnt_o, .pwm_o, .ovf_flag_o, .cmp_flag_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic start(input logic [1:0] m);
    @(negedge clk_i);
    rst_ni = 1'b0; cnt_en_i = 1'b0; mode_i = m;
    ocr_we_i = 1'b0; ovf_clr_i = 1'b0; cmp_clr_i = 1'b0;
    ticks(2);
    rst_ni = 1'b1;
  endtask

  task automatic wr_ocr(input logic [7:0] v);
    logic en_save;
    en_save = cnt_en_i;
    cnt_en_i = 1'b0; ocr_we_i = 1'b1; ocr_wdata_i = v;
    ticks(1);
    ocr_we_i = 1'b0; cnt_en_i = en_save;
  endtask

  task automatic clr_flags();
    logic en_save;
    en_save = cnt_en_i;
    cnt_en_i = 1'b0; ovf_clr_i = 1'b1; cmp_clr_i = 1'b1;
    ticks(1);
    ovf_clr_i = 1'b0; cmp_clr_i = 1'b0; cnt_en_i = en_save;
  endtask

  task automatic t_reset();
    start(2'd2);
    chk("R1 cnt", cnt_o, 0);
    chk("R1 pwm", pwm_o, 0);
    chk("R1 ovf", ovf_flag_o, 0);
    chk("R1 cmp", cmp_flag_o, 0);
  endtask

  task automatic t_wrap();
    start(2'd0);
    wr_ocr(8'd10);
    cnt_en_i = 1'b1;
    ticks(10);
    chk("R5 no flag at equality", cmp_flag_o, 0);
    chk("R6 pin before", pwm_o, 0);
    ticks(1);
    chk("R5 cnt", cnt_o, 11);
    chk("R5 flag one tick later", cmp_flag_o, 1);
    chk("R6 toggle", pwm_o, 1);
    cmp_clr_i = 1'b1; ticks(1); cmp_clr_i = 1'b0;
    chk("R11 clear", cmp_flag_o, 0);
    ticks(243);
    chk("R4 at top", cnt_o, 255);
    chk("R4 not yet", ovf_flag_o, 0);
    ovf_clr_i = 1'b1; ticks(1); ovf_clr_i = 1'b0;
    chk("R3 wrap", cnt_o, 0);
    chk("R11 set wins", ovf_flag_o, 1);
    ticks(256);
    chk("R3 period 256", cnt_o, 0);
    chk("R11 sticky", ovf_flag_o, 1);
    ticks(7);
    cnt_en_i = 1'b0;
    ticks(5);
    chk("R2 hold", cnt_o, 7);
  endtask

  task automatic t_ctc();
    start(2'd1);
    wr_ocr(8'd5);
    cnt_en_i = 1'b1;
    ticks(5);
    chk("R3 ctc at N", cnt_o, 5);
    chk("R5 ctc flag not yet", cmp_flag_o, 0);
    ticks(1);
    chk("R3 ctc restart", cnt_o, 0);
    chk("R5 ctc flag", cmp_flag_o, 1);
    chk("R6 ctc toggle", pwm_o, 1);
    ticks(6);
    chk("R3 ctc period N+1", cnt_o, 0);
    chk("R6 ctc toggle back", pwm_o, 0);
    chk("R4 ctc no ovf", ovf_flag_o, 0);
  endtask

  task automatic t_fast();
    start(2'd2);
    wr_ocr(8'd3);
    cnt_en_i = 1'b1;
    ticks(2);
    chk("R10 old value governs", pwm_o, 0);
    ticks(254);
    chk("R3 fast wrap", cnt_o, 0);
    chk("R7 high at bottom", pwm_o, 1);
    chk("R4 fast ovf", ovf_flag_o, 1);
    ticks(3);
    chk("R7 high at C", pwm_o, 1);
    ticks(1);
    chk("R7 low at C+1", pwm_o, 0);
    chk("R5 fast cmp", cmp_flag_o, 1);
    ticks(252);
    chk("R7 high again", pwm_o, 1);
    ticks(1);
    wr_ocr(8'd0);
    ticks(2);
    chk("R10 buffered high", pwm_o, 1);
    ticks(1);
    chk("R10 buffered low", pwm_o, 0);
    ticks(252);
    ticks(1);
    chk("R7 C=0 one tick", pwm_o, 0);
  endtask

  task automatic t_phase();
    start(2'd3);
    wr_ocr(8'd4);
    cnt_en_i = 1'b1;
    ticks(255);
    chk("R8 top", cnt_o, 255);
    ticks(1);
    chk("R8 turn", cnt_o, 254);
    ticks(254);
    chk("R8 bottom", cnt_o, 0);
    chk("R8 ovf at bottom", ovf_flag_o, 1);
    clr_flags();
    ticks(4);
    chk("R9 cmp same tick", cmp_flag_o, 1);
    chk("R9 up clears", pwm_o, 0);
    ticks(251 + 250);
    chk("R9 cnt 5 down", cnt_o, 5);
    chk("R9 before down match", pwm_o, 0);
    ticks(1);
    chk("R9 down sets same tick", pwm_o, 1);
    ticks(7);
    chk("R9 cnt 3 up", cnt_o, 3);
    chk("R9 still high", pwm_o, 1);
    ticks(1);
    chk("R9 up clears same tick", pwm_o, 0);
    wr_ocr(8'd255);
    ticks(506);
    chk("R10 bottom reached", cnt_o, 0);
    ticks(255);
    chk("R9 max drives high", pwm_o, 1);
    ticks(510);
    chk("R9 max stays high", pwm_o, 1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_wrap();
    t_ctc();
    t_fast();
    t_phase();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule